// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations for a processor core. A lookup presents a 32-bit virtual address, the current address space identifier and an access kind. Every stored entry is compared at once, and the outcome appears on the outputs in the same cycle without a register on the way. A permitted match returns the physical address. A match whose permissions forbid the access raises a fault, and no match raises a miss. An outside page walker resolves the miss and writes the result back through the fill port.

Entries have three page sizes: 4 KB, 2 MB and a 1 GB-class region. For the larger sizes the low virtual page bits are left out of the compare and pass straight through to the physical address. Entries can be invalidated all at once or selected by address space. A fill goes to the lowest-numbered empty slot. When there is none, it replaces the entry that was used least recently. Recency is tracked exactly across all slots.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so any lookup reports a miss.
- R2: A lookup in a given cycle is answered in that same cycle. A permitted hit on a 4 KB entry returns the entry's 20-bit frame number joined above the unchanged low 12 address bits.
- R3: A 4 KB entry matches only when all 20 virtual page bits (address bits 31:12) equal its tag. Any other page misses.
- R4: An entry whose address space identifier differs from the lookup's never matches, even when the tag is equal.
- R5: Size code 01 (2 MB) leaves address bits 20:12 out of the compare. Physical address bits 20:0 are copied from the virtual address.
- R6: Size code 10 compares only address bits 31:30. Physical address bits 29:0 are copied from the virtual address. Size code 11 behaves as 4 KB.
- R7: The permission field has bit 0 for read, bit 1 for write and bit 2 for execute. The access code is 00 read, 01 write, 10 execute, and 11 is never allowed. A match without the needed bit raises the fault flag instead of hit and drives a physical address of zero.
- R8: When several entries match, the one with the lowest index provides the result.
- R9: A fill is written into the lowest-index invalid entry when one exists.
- R10: When every entry is valid, a fill replaces the least recently used entry. Both a fill and a lookup match (hit or fault) make that entry the most recently used.
- R11: An invalidate-all request clears every entry in one cycle.
- R12: An invalidate-by-identifier request clears only the entries carrying that identifier.
- R13: While a lookup is requested, exactly one of hit, miss and fault is high. With no request all three are low. The physical address is zero unless hit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address space identifier |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No entry matched |
| lk_fault | output | 1 | Entry matched but access not permitted |
| lk_pa | output | 32 | Translated physical address (zero unless hit) |
| fill_en | input | 1 | Write a new entry |
| fill_vpn | input | 20 | Virtual page tag of the new entry |
| fill_pfn | input | 20 | Frame number of the new entry |
| fill_asid | input | 8 | Identifier of the new entry |
| fill_size | input | 2 | Page size code of the new entry |
| fill_perm | input | 3 | Permission bits {X,W,R} of the new entry |
| inv_all | input | 1 | Clear every entry |
| inv_asid_en | input | 1 | Clear entries matching inv_asid |
| inv_asid | input | 8 | Identifier to clear |

## Verification
The checker tests on every cycle that a lookup request has exactly one outcome, that the page offset passes through on a hit, and that the address is zero on a miss or fault. It also tests that invalidate-all empties the array, that a fill never overwrites a valid slot while an empty one exists, and that a freshly filled slot is never the next victim. Only the bench scenarios can show that eviction follows the true use order, that lowest-index priority holds between overlapping pages, that superpage masking and identifier isolation work, and that selective invalidation leaves the other identifiers untouched. These need chosen fill and lookup histories whose outcome is visible only at the ports.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W      = 32;
    localparam int OFS_W     = 12;
    localparam int VPN_W     = VA_W - OFS_W;
    localparam int PFN_W     = 20;
    localparam int ASID_W    = 8;
    localparam int SIZE_W    = 2;
    localparam int PERM_W    = 3;
    localparam int PA_W      = PFN_W + OFS_W;
    localparam int MID_SHIFT = 9;    // 2 MB page: low 9 page bits are offset
    localparam int BIG_SHIFT = 18;   // region: only top 2 page bits compared

    typedef enum logic [SIZE_W-1:0] {
        PG_4K   = 2'b00,
        PG_2M   = 2'b01,
        PG_1G   = 2'b10,
        PG_RSVD = 2'b11
    } pg_size_e;

    typedef enum logic [1:0] {
        ACC_RD   = 2'b00,
        ACC_WR   = 2'b01,
        ACC_EX   = 2'b10,
        ACC_RSVD = 2'b11
    } acc_e;

    typedef struct packed {
        logic                valid;
        logic [ASID_W-1:0]   asid;
        logic [VPN_W-1:0]    vpn;
        logic [PFN_W-1:0]    pfn;
        logic [SIZE_W-1:0]   size;
        logic [PERM_W-1:0]   perm;
    } xlat_ent_t;

    // ones mark page bits that take part in the compare / come from the frame
    function automatic logic [VPN_W-1:0] page_mask(input logic [SIZE_W-1:0] sz);
        logic [VPN_W-1:0] m;
        case (pg_size_e'(sz))
            PG_2M:   m = {VPN_W{1'b1}} << MID_SHIFT;
            PG_1G:   m = {VPN_W{1'b1}} << BIG_SHIFT;
            default: m = {VPN_W{1'b1}};
        endcase
        return m;
    endfunction

    function automatic logic acc_allowed(input logic [1:0] acc,
                                         input logic [PERM_W-1:0] perm);
        logic ok;
        case (acc_e'(acc))
            ACC_RD:  ok = perm[0];
            ACC_WR:  ok = perm[1];
            ACC_EX:  ok = perm[2];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_entry_cmp.sv
module xlat_entry_cmp
    import xlat_pkg::*;
(
    input  xlat_ent_t          ent,
    input  logic [VPN_W-1:0]   va_vpn,
    input  logic [ASID_W-1:0]  asid,
    output logic               match
);
    logic [VPN_W-1:0] mask;
    logic             tag_eq;

    always_comb begin
        mask   = page_mask(ent.size);
        tag_eq = ((ent.vpn ^ va_vpn) & mask) == '0;
        match  = ent.valid && tag_eq && (ent.asid == asid);
    end
endmodule

// File: rtl/xlat_first_set.sv
module xlat_first_set #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim_idx
);
    // age 0 = most recent, N-1 = least recent; ages always form a permutation
    typedef struct packed {
        logic [N-1:0][IW-1:0] age;
    } lru_st_t;

    lru_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    st_d.age[i] = '0;
                else if (st_q.age[i] < st_q.age[touch_idx])
                    st_d.age[i] = st_q.age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (st_q.age[i] == IW'(N - 1))
                victim_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                st_q.age[i] <= IW'(i);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_va,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [1:0]         lk_acc,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic               lk_fault,
    output logic [PA_W-1:0]    lk_pa,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PFN_W-1:0]   fill_pfn,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [SIZE_W-1:0]  fill_size,
    input  logic [PERM_W-1:0]  fill_perm,
    input  logic               inv_all,
    input  logic               inv_asid_en,
    input  logic [ASID_W-1:0]  inv_asid
);
    localparam int N  = NUM_ENTRIES;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        xlat_ent_t [N-1:0] ent;
    } cache_st_t;

    cache_st_t st_d, st_q;

    logic [VPN_W-1:0] va_vpn;
    logic [N-1:0]     match_vec;
    logic [N-1:0]     valid_vec;
    logic             hit_found;
    logic [IW-1:0]    hit_idx;
    logic             free_found;
    logic [IW-1:0]    free_idx;
    logic [IW-1:0]    victim_idx;
    logic [IW-1:0]    fill_idx;
    logic             touch_en;
    logic [IW-1:0]    touch_idx;
    xlat_ent_t        sel;
    logic [VPN_W-1:0] sel_mask;
    logic [PFN_W-1:0] out_pfn;
    logic             perm_ok;

    assign va_vpn = lk_va[VA_W-1:OFS_W];

    // parallel tag compare, one comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        xlat_entry_cmp u_cmp (
            .ent    (st_q.ent[g]),
            .va_vpn (va_vpn),
            .asid   (lk_asid),
            .match  (match_vec[g])
        );
        assign valid_vec[g] = st_q.ent[g].valid;
    end

    xlat_first_set #(.N(N)) u_hit_sel (
        .vec   (match_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    xlat_first_set #(.N(N)) u_free_sel (
        .vec   (~valid_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    xlat_lru #(.N(N)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    // lookup result path
    always_comb begin
        sel      = st_q.ent[hit_idx];
        sel_mask = page_mask(sel.size);
        out_pfn  = (sel.pfn & sel_mask) | (va_vpn & ~sel_mask);
        perm_ok  = acc_allowed(lk_acc, sel.perm);
        lk_hit   = lk_valid && hit_found && perm_ok;
        lk_fault = lk_valid && hit_found && !perm_ok;
        lk_miss  = lk_valid && !hit_found;
        lk_pa    = lk_hit ? {out_pfn, lk_va[OFS_W-1:0]} : '0;
    end

    // slot choice and recency update
    always_comb begin
        fill_idx  = free_found ? free_idx : victim_idx;
        touch_en  = fill_en || (lk_valid && hit_found);
        touch_idx = fill_en ? fill_idx : hit_idx;
    end

    // next state of the entry array
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (inv_all)
                st_d.ent[i].valid = 1'b0;
            else if (inv_asid_en && (st_q.ent[i].asid == inv_asid))
                st_d.ent[i].valid = 1'b0;
        end
        if (fill_en) begin
            st_d.ent[fill_idx].valid = 1'b1;
            st_d.ent[fill_idx].asid  = fill_asid;
            st_d.ent[fill_idx].vpn   = fill_vpn;
            st_d.ent[fill_idx].pfn   = fill_pfn;
            st_d.ent[fill_idx].size  = fill_size;
            st_d.ent[fill_idx].perm  = fill_perm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [VA_W-1:0]        lk_va,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic                   lk_fault,
    input logic [PA_W-1:0]        lk_pa,
    input logic                   fill_en,
    input logic                   inv_all,
    input logic                   inv_asid_en,
    input logic [NUM_ENTRIES-1:0] valid_vec,
    input logic [IW-1:0]          fill_idx,
    input logic [IW-1:0]          victim_idx
);
    assert_one_outcome_R13: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[OFS_W-1:0] == lk_va[OFS_W-1:0]));

    assert_no_pa_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault || lk_miss) |-> (lk_pa == '0));

    assert_inv_all_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !fill_en) |=> (valid_vec == '0));

    assert_free_slot_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(&valid_vec)) |-> !valid_vec[fill_idx]);

    assert_fill_not_victim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && (&valid_vec) && !inv_all && !inv_asid_en)
            |=> (victim_idx != $past(fill_idx)));
endmodule

bind xlat_cache xlat_cache_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_va       (lk_va),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_fault    (lk_fault),
    .lk_pa       (lk_pa),
    .fill_en     (fill_en),
    .inv_all     (inv_all),
    .inv_asid_en (inv_asid_en),
    .valid_vec   (valid_vec),
    .fill_idx    (fill_idx),
    .victim_idx  (victim_idx)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_va;
    logic [7:0]  lk_asid;
    logic [1:0]  lk_acc;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_pa;
    logic        fill_en;
    logic [19:0] fill_vpn, fill_pfn;
    logic [7:0]  fill_asid;
    logic [1:0]  fill_size;
    logic [2:0]  fill_perm;
    logic        inv_all, inv_asid_en;
    logic [7:0]  inv_asid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    xlat_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pa(lk_pa),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_asid(fill_asid), .fill_size(fill_size), .fill_perm(fill_perm),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected word: {hit, miss, fault, pa}
    task automatic lookup(input logic [31:0] va, input logic [7:0] asid,
                          input logic [1:0] acc, input logic [2:0] flags,
                          input logic [31:0] pa, input string req);
        logic [34:0] act, exp;
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_acc = acc;
        #2;
        act = {lk_hit, lk_miss, lk_fault, lk_pa};
        exp = {flags, pa};
        check(act === exp, req, 64'(act), 64'(exp));
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [7:0] asid, input logic [1:0] sz,
                        input logic [2:0] perm);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        fill_asid = asid; fill_size = sz; fill_perm = perm;
        @(posedge clk); #1;
        fill_en = 1'b0;
    endtask

    task automatic flush_all();
        @(negedge clk); inv_all = 1'b1;
        @(posedge clk); #1; inv_all = 1'b0;
    endtask

    task automatic flush_asid(input logic [7:0] a);
        @(negedge clk); inv_asid_en = 1'b1; inv_asid = a;
        @(posedge clk); #1; inv_asid_en = 1'b0;
    endtask

    localparam logic [2:0] HIT = 3'b100, MISS = 3'b010, FLT = 3'b001;

    task automatic t_reset();
        check({lk_hit, lk_miss, lk_fault} === 3'b000, "R13 idle outputs low",
              64'({lk_hit, lk_miss, lk_fault}), 64'd0);
        lookup(32'h0000_1000, 8'd0, 2'b00, MISS, 32'h0, "R1 empty after reset");
        lookup(32'h0010_0123, 8'd3, 2'b00, MISS, 32'h0, "R1 empty after reset");
    endtask

    task automatic t_basic();
        fill(20'h00010, 20'h0ABCD, 8'd3, 2'b00, 3'b111);
        lookup(32'h0001_0123, 8'd3, 2'b00, HIT, 32'h0ABC_D123, "R2 same-cycle hit");
        lookup(32'h0001_0FFF, 8'd3, 2'b10, HIT, 32'h0ABC_DFFF, "R2 offset kept");
        lookup(32'h0001_1123, 8'd3, 2'b00, MISS, 32'h0, "R3 other page");
        lookup(32'h8001_0123, 8'd3, 2'b00, MISS, 32'h0, "R3 top bit differs");
        lookup(32'h0001_0123, 8'd4, 2'b00, MISS, 32'h0, "R4 asid mismatch");
    endtask

    task automatic t_perm();
        fill(20'h00020, 20'h00777, 8'd3, 2'b00, 3'b001);
        lookup(32'h0002_0456, 8'd3, 2'b00, HIT, 32'h0077_7456, "R7 read allowed");
        lookup(32'h0002_0456, 8'd3, 2'b01, FLT, 32'h0, "R7 write denied");
        lookup(32'h0002_0456, 8'd3, 2'b10, FLT, 32'h0, "R7 exec denied");
        lookup(32'h0002_0456, 8'd3, 2'b11, FLT, 32'h0, "R7 code 11 denied");
        fill(20'h00021, 20'h00888, 8'd3, 2'b00, 3'b110);
        lookup(32'h0002_1000, 8'd3, 2'b01, HIT, 32'h0088_8000, "R7 write allowed");
        lookup(32'h0002_1000, 8'd3, 2'b00, FLT, 32'h0, "R7 read denied");
    endtask

    task automatic t_sizes();
        fill(20'h12345, 20'h55555, 8'd3, 2'b01, 3'b111);
        lookup(32'h123F_FABC, 8'd3, 2'b00, HIT, 32'h555F_FABC, "R5 2MB match");
        lookup(32'h1240_0ABC, 8'd3, 2'b00, MISS, 32'h0, "R5 2MB outside");
        fill(20'h80000, 20'hC0000, 8'd3, 2'b10, 3'b111);
        lookup(32'h9ABC_D123, 8'd3, 2'b00, HIT, 32'hDABC_D123, "R6 region match");
        lookup(32'h4000_0000, 8'd3, 2'b00, MISS, 32'h0, "R6 region outside");
        fill(20'h00030, 20'h00333, 8'd3, 2'b11, 3'b111);
        lookup(32'h0003_0010, 8'd3, 2'b00, HIT, 32'h0033_3010, "R6 code 11 as 4KB");
        lookup(32'h0003_1010, 8'd3, 2'b00, MISS, 32'h0, "R6 code 11 as 4KB");
    endtask

    task automatic t_multi();
        flush_all();
        fill(20'h30000, 20'h11000, 8'd5, 2'b01, 3'b111);
        fill(20'h30005, 20'h22222, 8'd5, 2'b00, 3'b111);
        lookup(32'h3000_5010, 8'd5, 2'b00, HIT, 32'h1100_5010, "R8 lowest index wins");
    endtask

    task automatic t_free_and_asid();
        flush_all();
        lookup(32'h3000_5010, 8'd5, 2'b00, MISS, 32'h0, "R11 flush all");
        for (int i = 0; i < 16; i++)
            fill(20'h00400 + 20'(i), 20'h01000 + 20'(i),
                 (i == 3 || i == 7) ? 8'd9 : 8'd1, 2'b00, 3'b111);
        flush_asid(8'd9);
        lookup(32'h0040_3000, 8'd9, 2'b00, MISS, 32'h0, "R12 asid 9 cleared");
        lookup(32'h0040_7000, 8'd9, 2'b00, MISS, 32'h0, "R12 asid 9 cleared");
        fill(20'h00500, 20'h02000, 8'd1, 2'b00, 3'b111);
        fill(20'h00501, 20'h02001, 8'd1, 2'b00, 3'b111);
        for (int i = 0; i < 16; i++) begin
            if (i != 3 && i != 7)
                lookup({20'h00400 + 20'(i), 12'h0}, 8'd1, 2'b00, HIT,
                       {20'h01000 + 20'(i), 12'h0}, "R9 R12 kept entries");
        end
        lookup(32'h0050_0000, 8'd1, 2'b00, HIT, 32'h0200_0000, "R9 fill into free slot");
        lookup(32'h0050_1000, 8'd1, 2'b00, HIT, 32'h0200_1000, "R9 fill into free slot");
    endtask

    task automatic t_lru();
        flush_all();
        for (int i = 0; i < 16; i++)
            fill(20'h00100 + 20'(i), 20'h03000 + 20'(i), 8'd2, 2'b00, 3'b111);
        lookup(32'h0010_0000, 8'd2, 2'b00, HIT, 32'h0300_0000, "R10 touch oldest");
        fill(20'h00200, 20'h04000, 8'd2, 2'b00, 3'b111);
        lookup(32'h0010_1000, 8'd2, 2'b00, MISS, 32'h0, "R10 LRU evicted");
        lookup(32'h0010_0000, 8'd2, 2'b00, HIT, 32'h0300_0000, "R10 touched kept");
        lookup(32'h0020_0000, 8'd2, 2'b00, HIT, 32'h0400_0000, "R10 new entry");
        lookup(32'h0010_2000, 8'd2, 2'b00, HIT, 32'h0300_2000, "R10 touch next");
        fill(20'h00201, 20'h04001, 8'd2, 2'b00, 3'b111);
        lookup(32'h0010_3000, 8'd2, 2'b00, MISS, 32'h0, "R10 second eviction");
        lookup(32'h0010_2000, 8'd2, 2'b00, HIT, 32'h0300_2000, "R10 refreshed kept");
        flush_all();
        lookup(32'h0020_0000, 8'd2, 2'b00, MISS, 32'h0, "R11 flush all");
        lookup(32'h0010_0000, 8'd2, 2'b00, MISS, 32'h0, "R11 flush all");
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_asid = '0; lk_acc = '0;
        fill_en = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_asid = '0;
        fill_size = '0; fill_perm = '0;
        inv_all = 1'b0; inv_asid_en = 1'b0; inv_asid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_basic();
        t_perm();
        t_sizes();
        t_multi();
        t_free_and_asid();
        t_lru();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule